// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block is the hazard controller of a five-stage in-order pipeline (fetch, decode/register read, execute, memory, writeback), where each stage is separated from the next by a pipeline register. It watches the register indices carried in those registers. For each of the two ALU operands of the instruction now in execute, it picks where the value comes from: the register file, the result waiting in the memory-stage register, or the result waiting in the writeback-stage register. This way a dependent instruction can use a result before that result reaches the register file.

A load's data only exists after the memory stage, so no bypass can serve the instruction directly behind the load. When a load in execute writes a register that the instruction in decode reads, the block raises a one-cycle interlock. During that cycle it holds the program counter, holds the fetch/decode register, and turns the execute-stage entry into a bubble that writes nothing. A two-state machine makes sure the interlock never lasts more than one cycle. It has two states, RUN (interlock allowed) and HELD (the cycle right after an interlock, when no interlock is raised). There are two transitions: RUN→HELD when a load-use hazard is seen, and HELD→RUN unconditionally.

The register file is assumed to be written in the first half of a cycle and read in the second half. Because of that, no decode-stage bypass is needed from writeback. Register index zero is hard-wired and never produces a bypass or an interlock.

Top module: `hzd_unit`

## Requirements
- R1: When the memory-stage producer has its write enable set, a nonzero destination, and a destination equal to the execute-stage first source, `fwd_a` is 2'b10 in the same cycle.
- R2: When only the writeback-stage producer matches (write enable set, nonzero destination equal to the source), the select is 2'b01.
- R3: When both producers match the same source, the memory-stage producer wins (2'b10).
- R4: A destination index of 0 never causes a bypass select other than 2'b00 and never causes an interlock.
- R5: A producer whose write enable is low never causes a bypass, whatever its destination index.
- R6: With no qualifying producer, the select is 2'b00 (register file); the code 2'b11 never appears.
- R7: `fwd_b` follows the rules of R1–R6 for the execute-stage second source, independently of `fwd_a`.
- R8: When the execute stage holds a load (`ex_is_load` and `ex_we` high) with a nonzero destination equal to either decode-stage source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in that same cycle.
- R9: In the cycle after an interlock, all three interlock outputs are 0, even if the hazard inputs remain.
- R10: A non-load producer in execute never causes an interlock.
- R11: While reset is held and in the first cycle after it, the machine is in RUN, so a load-use hazard raises the interlock at once; with idle inputs all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the interlock state |
| id_rs1 | input | 5 | First source index of the instruction in decode |
| id_rs2 | input | 5 | Second source index of the instruction in decode |
| ex_rs1 | input | 5 | First source index of the instruction in execute |
| ex_rs2 | input | 5 | Second source index of the instruction in execute |
| ex_rd | input | 5 | Destination index of the instruction in execute |
| ex_we | input | 1 | Register write enable of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | 5 | Destination index in the memory-stage register |
| mem_we | input | 1 | Register write enable in the memory-stage register |
| wb_rd | input | 5 | Destination index in the writeback-stage register |
| wb_we | input | 1 | Register write enable in the writeback-stage register |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a no-write bubble into the execute-stage register |

## Verification
Every cycle, the assertions check that a memory-stage select is justified by a live, nonzero, matching producer and that this producer wins over writeback. They also check that a writeback select never hides a memory-stage match, that the unused code never shows up, that an interlock has a real load-use cause, and that an interlock is never followed by a second one. Whether a qualifying match really yields the expected select on both operands independently, and whether a hazard held for several cycles gives the stall/release/stall cadence, can only be seen in the bench's scenarios. Those scenarios are random with small index ranges, so matches are frequent, plus directed cases for x0, disabled writers and back-to-back hazards.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Operand source select driven toward the execute-stage operand muxes
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    // Interlock sequencing: RUN allows an interlock, HELD is the cycle after one
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HELD = 1'b1
    } ilk_state_e;

endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_idx,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output fwd_sel_e      sel
);

    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic mem_hit;
    logic wb_hit;

    // A producer only qualifies when it writes and its target is not the zero register
    always_comb begin
        mem_hit = mem_we && (mem_rd != ZERO_IDX) && (mem_rd == src_idx);
        wb_hit  = wb_we  && (wb_rd  != ZERO_IDX) && (wb_rd  == src_idx);
    end

    // The younger result (memory stage) takes priority over the older one
    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = FWD_MEM;
            2'b01:        sel = FWD_WB;
            default:      sel = FWD_RF;
        endcase
    end

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    output logic          hazard
);

    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic load_live;
    logic src_match;

    always_comb begin
        load_live = ex_is_load && ex_we && (ex_rd != ZERO_IDX);
        src_match = (ex_rd == id_rs1) || (ex_rd == id_rs2);
        hazard    = load_live && src_match;
    end

endmodule

// File: rtl/hzd_ilk_fsm.sv
module hzd_ilk_fsm
    import hzd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);

    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RUN->HELD on hazard, HELD->RUN always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (hazard) state_d = ST_HELD;
            ST_HELD: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs: an interlock can only be raised from RUN
    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            ST_RUN:  stall = hazard;
            ST_HELD: stall = 1'b0;
            default: stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);

    localparam int NSRC = 2;

    logic [AW-1:0] ex_src [NSRC];
    fwd_sel_e      src_sel [NSRC];
    logic          lu_hazard;
    logic          ilk_stall;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        hzd_fwd_pick #(.AW(AW)) u_pick (
            .src_idx (ex_src[g]),
            .mem_rd  (mem_rd),
            .mem_we  (mem_we),
            .wb_rd   (wb_rd),
            .wb_we   (wb_we),
            .sel     (src_sel[g])
        );
    end

    assign fwd_a = src_sel[0];
    assign fwd_b = src_sel[1];

    hzd_load_use #(.AW(AW)) u_lu (
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .hazard     (lu_hazard)
    );

    hzd_ilk_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (lu_hazard),
        .stall  (ilk_stall)
    );

    assign pc_hold     = ilk_stall;
    assign ifid_hold   = ilk_stall;
    assign idex_bubble = ilk_stall;

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs1,
    input logic [AW-1:0] id_rs2,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic [AW-1:0] ex_rd,
    input logic          ex_we,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic [AW-1:0] wb_rd,
    input logic          wb_we,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble
);

    AST_MEM_SEL_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == 2'b10) |-> (mem_we && (mem_rd != '0) && (mem_rd == ex_rs1))); // R1

    AST_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_rd != '0) && (mem_rd == ex_rs2)) |-> (fwd_b == 2'b10)); // R3

    AST_WB_SEL_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_b == 2'b01) |-> (wb_we && (wb_rd != '0) && (wb_rd == ex_rs2)
                              && !(mem_we && (mem_rd != '0) && (mem_rd == ex_rs2)))); // R2

    AST_NO_SPARE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R6

    AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_is_load && ex_we && (ex_rd != '0)
                     && ((ex_rd == id_rs1) || (ex_rd == id_rs2)))); // R8

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !idex_bubble); // R9

    AST_X0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !ifid_hold); // R4

endmodule

bind hzd_unit hzd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_hzd_unit.sv
`timescale 1ns/1ps
module sim_hzd_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [4:0] mem_rd = '0, wb_rd = '0;
    logic       ex_we = 1'b0, ex_is_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_hold, ifid_hold, idex_bubble;

    int errors = 0;
    int checks = 0;
    bit prev_stall = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hzd_unit u0 (.*);

    function automatic logic [1:0] exp_sel(input logic [4:0] s);
        if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_we && wb_rd != 0 && wb_rd == s)    return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit exp_hazard();
        return ex_is_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    function automatic string sel_tag(input logic [4:0] s);
        bit m = mem_we && mem_rd == s;
        bit w = wb_we && wb_rd == s;
        if ((m && mem_rd == 0) || (w && wb_rd == 0)) return "R4";
        if (mem_rd == s && !mem_we) return "R5";
        if (m && w) return "R3";
        if (m) return "R1";
        if (w) return "R2";
        return "R6";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Inputs are already applied; sample mid-low phase, then advance the model past the edge
    task automatic eval_cycle(input string stall_tag);
        bit es;
        #1;
        es = exp_hazard() && !prev_stall;
        chk(sel_tag(ex_rs1), fwd_a, exp_sel(ex_rs1));
        chk({sel_tag(ex_rs2), " R7"}, fwd_b, exp_sel(ex_rs2));
        chk(stall_tag, {pc_hold, ifid_hold, idex_bubble}, es ? 7 : 0);
        @(posedge clk);
        prev_stall = rst_n ? es : 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        mem_rd = 0; wb_rd = 0; ex_we = 0; ex_is_load = 0; mem_we = 0; wb_we = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        idle();
        eval_cycle("R11");                       // reset, idle inputs
        ex_is_load = 1; ex_we = 1; ex_rd = 5; id_rs1 = 5;
        eval_cycle("R11");                       // hazard during reset stalls at once
        idle();
        rst_n = 1'b1;
        eval_cycle("R11");

        // R1/R2 separately, then R3 priority
        ex_rs1 = 7; mem_we = 1; mem_rd = 7; eval_cycle("R10");
        idle(); ex_rs1 = 7; wb_we = 1; wb_rd = 7; eval_cycle("R10");
        mem_we = 1; mem_rd = 7; eval_cycle("R10");
        // R5: disabled writers
        idle(); ex_rs1 = 9; ex_rs2 = 9; mem_rd = 9; wb_rd = 9; eval_cycle("R10");
        // R4: x0 destinations everywhere
        idle(); mem_we = 1; wb_we = 1; ex_we = 1; ex_is_load = 1; eval_cycle("R4");
        // R7: operands independent
        idle(); ex_rs1 = 3; ex_rs2 = 4; mem_we = 1; mem_rd = 4; wb_we = 1; wb_rd = 3;
        eval_cycle("R10");
        // R10: non-load producer matching decode source
        idle(); ex_we = 1; ex_rd = 6; id_rs2 = 6; eval_cycle("R10");
        // R8/R9: persistent load-use hazard -> stall, release, stall
        ex_is_load = 1; id_rs1 = 0;
        eval_cycle("R8"); eval_cycle("R9"); eval_cycle("R8"); eval_cycle("R9");
        // R8 via first source, load with write disabled does not stall
        idle(); ex_is_load = 1; ex_we = 1; ex_rd = 2; id_rs1 = 2; eval_cycle("R8");
        idle(); ex_is_load = 1; ex_rd = 2; id_rs1 = 2; eval_cycle("R5");

        for (int i = 0; i < 3000; i++) begin
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            ex_rd  = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
            wb_rd  = 5'($urandom_range(0, 3));
            ex_we = 1'($urandom); ex_is_load = 1'($urandom);
            mem_we = 1'($urandom); wb_we = 1'($urandom);
            eval_cycle(prev_stall ? "R9" : (ex_is_load ? "R8" : "R10"));
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule